// File: doc/BRIEF.md
# Floppy Controller Rate and Power Control Register

This block holds the write-only control register that sets the data rate, the write precompensation delay, manual power-down and a software reset for a floppy disk controller. It decodes byte writes on a small I/O window and also takes a separate write strobe from a configuration control register. Both sources feed one data-rate register, and whichever source wrote most recently sets the value.

The precompensation field is turned into a delay counted in ticks of a 24 MHz clock. One tick is about 41.67 ns. Manual power-down is set by a register bit. It ends when the controller is reset, or when the data register or the main status register is accessed. The reset bit clears itself. It produces a controller reset pulse of fixed length, which is ORed with an external reset bit from the digital output register.

Top module: `fdc_rate_ctl`

## Requirements
- R1: While and after hardware reset (rst_n low), rate is 2, prec_ticks is DEF_TICKS (default 3), low_pwr is 0 and ctl_rst equals dor_rst.
- R2: A write with addr equal to RATE_OFS (default 4) loads rate from wdata[1:0], visible after that clock edge. A write to any other offset leaves every output unchanged.
- R3: A pulse on ccr_wr loads rate from ccr_rate, so rate follows the most recent writer. If both write in the same cycle, the value from the bus write at RATE_OFS wins.
- R4: The precompensation code sits in wdata[4:2]. Code 3'b111 gives prec_ticks 0, codes 3'b001 to 3'b110 give prec_ticks equal to the code, and code 3'b000 gives DEF_TICKS.
- R5: Writing 1 to wdata[6] at RATE_OFS, with wdata[7] at 0, sets low_pwr after that edge. Writing 0 there clears it.
- R6: A pulse on dr_acc or msr_acc clears low_pwr at the next edge. This clear takes priority over a write in the same cycle.
- R7: Writing 1 to wdata[7] at RATE_OFS drives ctl_rst high for exactly RST_CYCLES (default 4) cycles, starting after that edge, and then it drops by itself. While ctl_rst is high, low_pwr is cleared.
- R8: ctl_rst is the OR of the internal reset pulse and dor_rst, with no register delay from dor_rst.
- R9: A software reset, whether from wdata[7] or from dor_rst, does not change rate or prec_ticks. Only a hardware reset restores them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Offset within the controller I/O window |
| wdata | input | 8 | Bus write data |
| ccr_wr | input | 1 | Configuration control register write strobe |
| ccr_rate | input | 2 | Data-rate code written by the configuration control register |
| dr_acc | input | 1 | Access to the data register |
| msr_acc | input | 1 | Access to the main status register |
| dor_rst | input | 1 | Reset bit from the digital output register |
| rate | output | 2 | Effective data-rate code |
| prec_ticks | output | TICK_W | Precompensation delay in 24 MHz ticks |
| low_pwr | output | 1 | Manual low-power mode active |
| ctl_rst | output | 1 | Controller reset (internal pulse OR dor_rst) |

## Verification
Each registered result (rate, prec_ticks, low_pwr and the start of the reset pulse) is due one edge after the strobe that causes it. The bench therefore raises the strobe after a falling edge, waits for the next rising edge, lowers the strobe and samples 1 ns later. ctl_rst follows dor_rst in the same cycle, so that case is sampled 1 ns after the input changes, with no edge in between. The reset pulse length is checked by sampling after each of the RST_CYCLES edges and again after the edge that follows them.

// File: rtl/fdc_rate_ctl.sv
module fdc_rate_ctl #(
  parameter int ADDR_W     = 3,
  parameter int RATE_OFS   = 4,
  parameter int TICK_W     = 3,
  parameter int DEF_TICKS  = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              ccr_wr,
  input  logic [1:0]        ccr_rate,
  input  logic              dr_acc,
  input  logic              msr_acc,
  input  logic              dor_rst,
  output logic [1:0]        rate,
  output logic [TICK_W-1:0] prec_ticks,
  output logic              low_pwr,
  output logic              ctl_rst
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [1:0] RATE_INIT = 2'd2;

  logic             hit;
  logic [2:0]       prec_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pulse;

  assign hit     = wr_en && (addr == ADDR_W'(RATE_OFS));
  assign pulse   = (cnt_q != '0);
  assign ctl_rst = pulse | dor_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate   <= RATE_INIT;
      prec_q <= 3'b000;
    end else if (hit) begin
      rate   <= wdata[1:0];
      prec_q <= wdata[4:2];
    end else if (ccr_wr) begin
      rate   <= ccr_rate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (hit && wdata[7])
      cnt_q <= CNT_W'(RST_CYCLES);
    else if (pulse)
      cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_pwr <= 1'b0;
    else if (dr_acc || msr_acc || ctl_rst)
      low_pwr <= 1'b0;
    else if (hit)
      low_pwr <= wdata[6] & ~wdata[7];
  end

  always_comb begin
    case (prec_q)
      3'b111:  prec_ticks = '0;
      3'b000:  prec_ticks = TICK_W'(DEF_TICKS);
      default: prec_ticks = TICK_W'(prec_q);
    endcase
  end

endmodule

// File: rtl/fdc_rate_ctl_chk.sv
module fdc_rate_ctl_chk #(
  parameter int ADDR_W    = 3,
  parameter int RATE_OFS  = 4,
  parameter int TICK_W    = 3,
  parameter int DEF_TICKS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              ccr_wr,
  input logic [1:0]        ccr_rate,
  input logic              dr_acc,
  input logic              msr_acc,
  input logic              dor_rst,
  input logic [1:0]        rate,
  input logic [TICK_W-1:0] prec_ticks,
  input logic              low_pwr,
  input logic              ctl_rst
);

  logic hit;
  assign hit = wr_en && (addr == ADDR_W'(RATE_OFS));

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (rate == 2'd2 && prec_ticks == TICK_W'(DEF_TICKS) && !low_pwr));

  p_bus_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> rate == $past(wdata[1:0]));

  p_ccr_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_wr && !hit) |=> rate == $past(ccr_rate));

  p_rate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !ccr_wr) |=> $stable(rate) && $stable(prec_ticks));

  p_pd_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_acc || msr_acc) |=> !low_pwr);

  p_pd_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wdata[6] && !wdata[7] && !dr_acc && !msr_acc && !ctl_rst) |=> low_pwr);

  p_sw_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wdata[7]) |=> ctl_rst && !low_pwr);

  p_dor_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dor_rst |-> ctl_rst);

endmodule

bind fdc_rate_ctl fdc_rate_ctl_chk #(
  .ADDR_W(ADDR_W), .RATE_OFS(RATE_OFS), .TICK_W(TICK_W), .DEF_TICKS(DEF_TICKS)
) u_chk (.*);

// File: tb/fdc_rate_ctl_bench.sv
`timescale 1ns/1ps
module fdc_rate_ctl_bench;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, ccr_wr = 0, dr_acc = 0, msr_acc = 0, dor_rst = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [1:0] ccr_rate = 0;
  logic [1:0] rate;
  logic [2:0] prec_ticks;
  logic       low_pwr, ctl_rst;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  fdc_rate_ctl u_fdc_rate_ctl (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic ccr(logic [1:0] r);
    @(negedge clk); ccr_wr = 1; ccr_rate = r;
    @(posedge clk); #1; ccr_wr = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 rate", rate, 2); chk("R1 prec", prec_ticks, 3);
    chk("R1 low_pwr", low_pwr, 0); chk("R1 ctl_rst", ctl_rst, 0);
  endtask

  task automatic t_rate();
    wr(3'd4, 8'h01); chk("R2 rate", rate, 1);
    wr(3'd5, 8'h03); chk("R2 other offset rate", rate, 1);
    chk("R2 other offset prec", prec_ticks, 3);
    chk("R2 other offset low_pwr", low_pwr, 0);
  endtask

  task automatic t_ccr();
    ccr(2'd3); chk("R3 ccr last", rate, 3);
    wr(3'd4, 8'h00); chk("R3 reg last", rate, 0);
    @(negedge clk); wr_en = 1; addr = 4; wdata = 8'h01; ccr_wr = 1; ccr_rate = 2'd2;
    @(posedge clk); #1; wr_en = 0; ccr_wr = 0;
    chk("R3 same cycle", rate, 1);
  endtask

  task automatic t_prec();
    wr(3'd4, 8'h1C); chk("R4 code 111", prec_ticks, 0);
    for (int c = 1; c < 7; c++) begin
      wr(3'd4, 8'(c << 2)); chk("R4 code n", prec_ticks, c);
    end
    wr(3'd4, 8'h00); chk("R4 code 000", prec_ticks, 3);
  endtask

  task automatic t_power();
    wr(3'd4, 8'h40); chk("R5 set", low_pwr, 1);
    wr(3'd4, 8'h00); chk("R5 clear by write", low_pwr, 0);
    wr(3'd4, 8'h40);
    @(negedge clk); dr_acc = 1; @(posedge clk); #1; dr_acc = 0;
    chk("R6 data reg access", low_pwr, 0);
    wr(3'd4, 8'h40);
    @(negedge clk); msr_acc = 1; wr_en = 1; addr = 4; wdata = 8'h40;
    @(posedge clk); #1; msr_acc = 0; wr_en = 0;
    chk("R6 status access wins", low_pwr, 0);
  endtask

  task automatic t_swrst();
    wr(3'd4, 8'h49);
    chk("R9 pre rate", rate, 1); chk("R9 pre prec", prec_ticks, 2);
    wr(3'd4, 8'h89);
    chk("R7 pulse cycle 1", ctl_rst, 1); chk("R7 low_pwr cleared", low_pwr, 0);
    for (int i = 2; i <= 4; i++) begin
      @(posedge clk); #1; chk("R7 pulse held", ctl_rst, 1);
    end
    @(posedge clk); #1; chk("R7 self clear", ctl_rst, 0);
    chk("R9 rate kept", rate, 1); chk("R9 prec kept", prec_ticks, 2);
  endtask

  task automatic t_dor();
    @(negedge clk); dor_rst = 1; #1;
    chk("R8 merge", ctl_rst, 1);
    @(posedge clk); #1; @(negedge clk); dor_rst = 0; #1;
    chk("R8 release", ctl_rst, 0);
    chk("R9 rate after dor", rate, 1);
    wr(3'd4, 8'h40); chk("R5 set again", low_pwr, 1);
    @(negedge clk); dor_rst = 1; @(posedge clk); #1; dor_rst = 0;
    chk("R7 reset ends low power", low_pwr, 0);
  endtask

  task automatic t_hwreset();
    @(negedge clk); rst_n = 0; #1;
    chk("R1 hw rate", rate, 2); chk("R1 hw prec", prec_ticks, 3);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #200 rst_n = 0;
    repeat (2) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_rate(); t_ccr(); t_prec(); t_power(); t_swrst(); t_dor(); t_hwreset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule